// File: doc/BRIEF.md
# Duty-Dependent Loss Resistance Monitor

This block watches the health of a digitally controlled forward converter by estimating, once per switching cycle, the lumped resistance whose conduction loss scales with the duty cycle. A rise in that resistance mostly reflects a rise in the power switch on-resistance. The inputs are signals the controller already holds: the commanded duty code, the input and output voltage samples, and the load current sampled at the middle of the on-time. Two calibration constants from a bench curve fit are also supplied: the diode drop and the duty-independent resistance.

The estimate is RX = (D·Vg − V − VD − RY·I) / (D·I). This arrangement needs a single sequential divider and no lookup table. A cycle starts on a strobe. If the duty or the current is too small to give a meaningful quotient, the cycle is skipped. Each new estimate is compared against a programmable trip level. An alarm with a separate clear level and a consecutive-count filter flags a switch that has degraded.

The controller has three states. S_IDLE captures all inputs on a strobe and moves to S_PREP. S_PREP either returns to S_IDLE (skip) or starts the divider and moves to S_DIV. S_DIV waits for the divider's done pulse, publishes the estimate and returns to S_IDLE. The alarm filter has two states. A_CLEAR moves to A_TRIP after enough consecutive high estimates. A_TRIP moves to A_CLEAR on an estimate below the clear level.

Top module: `lossres_monitor`

## Requirements
- R1: After reset, rx_est is 0, rx_valid is 0 and rx_alarm is 0.
- R2: With default parameters, duty_code d is the duty as d/1024. Voltages share one LSB unit, and iload_code uses one current LSB unit. rfix_cal and rx_est are resistances in (voltage LSB / current LSB)/256. rx_est = floor((d·vin·256 − (vout+diode)·262144 − rfix·iload·1024) / (d·iload)).
- R3: When the numerator of R2 is zero or negative, the published estimate is 0.
- R4: A quotient above 65535 is published as 65535.
- R5: A cycle whose captured duty_code is below 16 or whose iload_code is below 8 is skipped. No rx_valid pulse follows, rx_est holds its previous value, and the alarm's consecutive count is left untouched.
- R6: A strobe that arrives while a cycle is in progress is ignored. The result reflects the inputs captured at the accepted strobe, and only one rx_valid pulse appears.
- R7: rx_valid is a one-cycle pulse. It is first high after the 33rd rising edge counted from the edge that samples the strobe, and rx_est changes only together with it.
- R8: rx_alarm rises after three consecutive published estimates strictly above trip_level.
- R9: A published estimate not above trip_level restarts the consecutive count.
- R10: Once raised, rx_alarm stays high for estimates at or above clear_level. It falls on the first published estimate strictly below clear_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | Once-per-switching-cycle sample strobe |
| duty_code | input | 10 | Commanded duty, fraction of 1024 |
| vin_code | input | 12 | Input voltage sample |
| vout_code | input | 12 | Output voltage sample |
| iload_code | input | 12 | Load current sampled at mid on-time |
| diode_cal | input | 12 | Calibrated diode drop, voltage units |
| rfix_cal | input | 16 | Calibrated duty-independent resistance |
| trip_level | input | 16 | Alarm set threshold |
| clear_level | input | 16 | Alarm clear threshold |
| rx_est | output | 16 | Resistance estimate |
| rx_valid | output | 1 | Pulse when rx_est is updated |
| rx_alarm | output | 1 | Degraded-switch flag |

## Verification
The assertions assume three things about the inputs. The calibration values and both alarm levels stay constant while a cycle is in flight. clear_level is at or below trip_level, so the hysteresis band is not inverted. The operand minimums are at least 1, so the divider never sees a zero denominator. The stimulus changes calibration and thresholds only between cycles, after the published result and the alarm update have settled. It always uses a clear level below the trip level. It reaches the skip path only through duty or current codes under the minimums, so every division the checks observe has a nonzero divisor.

// File: rtl/lossres_pkg.sv
package lossres_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PREP = 2'd1,
        S_DIV  = 2'd2
    } seq_state_t;

    typedef enum logic {
        A_CLEAR = 1'b0,
        A_TRIP  = 1'b1
    } alarm_state_t;

endpackage

// File: rtl/lossres_operand.sv
module lossres_operand #(
    parameter int DUTY_W   = 10,
    parameter int V_W      = 12,
    parameter int I_W      = 12,
    parameter int RX_W     = 16,
    parameter int RES_FRAC = 8,
    parameter int DUTY_MIN = 16,
    parameter int CUR_MIN  = 8,
    localparam int NUM_W   = DUTY_W + V_W + RES_FRAC,
    localparam int DEN_W   = DUTY_W + I_W
) (
    input  logic [DUTY_W-1:0] duty,
    input  logic [V_W-1:0]    vin,
    input  logic [V_W-1:0]    vout,
    input  logic [V_W-1:0]    vdrop,
    input  logic [I_W-1:0]    iload,
    input  logic [RX_W-1:0]   rfix,
    output logic [NUM_W-1:0]  numer,
    output logic [DEN_W-1:0]  denom,
    output logic              skip
);
    localparam int SUM_W = DUTY_W + V_W + I_W + RX_W + RES_FRAC + 2;

    logic [SUM_W-1:0] drive_term;
    logic [SUM_W-1:0] out_term;
    logic [SUM_W-1:0] res_term;
    logic [SUM_W-1:0] loss_sum;
    logic [SUM_W-1:0] diff;

    always_comb begin
        drive_term = (SUM_W'(duty) * SUM_W'(vin)) << RES_FRAC;
        out_term   = (SUM_W'(vout) + SUM_W'(vdrop)) << (DUTY_W + RES_FRAC);
        res_term   = (SUM_W'(rfix) * SUM_W'(iload)) << DUTY_W;
        loss_sum   = out_term + res_term;
        diff       = drive_term - loss_sum;
        if (drive_term > loss_sum) begin
            numer = diff[NUM_W-1:0];
        end else begin
            numer = '0;
        end
        denom = DEN_W'(duty) * DEN_W'(iload);
        skip  = (int'(duty) < DUTY_MIN) || (int'(iload) < CUR_MIN);
    end

    initial begin
        if (DUTY_MIN < 1 || CUR_MIN < 1) begin
            $display("lossres_operand: minimums must be at least 1");
        end
    end
endmodule

// File: rtl/lossres_divider.sv
module lossres_divider #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num_in,
    input  logic [DEN_W-1:0] den_in,
    output logic [NUM_W-1:0] quot,
    output logic             done
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam int PW    = NUM_W + DEN_W + 1;

    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] quo;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   trial;
    logic             step_bit;
    logic [DEN_W-1:0] step_rem;

    always_comb begin
        shifted = {rem, quo[NUM_W-1]};
        trial   = shifted - {1'b0, den_q};
        if (shifted >= {1'b0, den_q}) begin
            step_bit = 1'b1;
            step_rem = trial[DEN_W-1:0];
        end else begin
            step_bit = 1'b0;
            step_rem = shifted[DEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            num_q <= '0;
            den_q <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                quo   <= num_in;
                num_q <= num_in;
                den_q <= den_in;
                cnt   <= CNT_W'(NUM_W);
            end else if (cnt != '0) begin
                rem <= step_rem;
                quo <= {quo[NUM_W-2:0], step_bit};
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = quo;

    logic [PW-1:0] chk_lo;
    logic [PW-1:0] chk_hi;
    logic [PW-1:0] chk_num;
    always_comb begin
        chk_lo  = PW'(quo) * PW'(den_q);
        chk_hi  = chk_lo + PW'(den_q);
        chk_num = PW'(num_q);
    end

    // R2: the finished quotient is the floor of numerator over denominator
    p_quot_exact_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_lo <= chk_num) && (chk_hi > chk_num));
endmodule

// File: rtl/lossres_alarm.sv
module lossres_alarm
    import lossres_pkg::*;
#(
    parameter int RX_W       = 16,
    parameter int TRIP_COUNT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic [RX_W-1:0] rx,
    input  logic [RX_W-1:0] set_lvl,
    input  logic [RX_W-1:0] clr_lvl,
    output logic            alarm
);
    localparam int CW = $clog2(TRIP_COUNT + 1);

    alarm_state_t st, st_nx;
    logic [CW-1:0] over_cnt, over_cnt_nx;

    always_comb begin
        st_nx       = st;
        over_cnt_nx = over_cnt;
        if (upd) begin
            unique case (st)
                A_CLEAR: begin
                    if (rx > set_lvl) begin
                        if (over_cnt == CW'(TRIP_COUNT - 1)) begin
                            st_nx       = A_TRIP;
                            over_cnt_nx = '0;
                        end else begin
                            over_cnt_nx = over_cnt + 1'b1;
                        end
                    end else begin
                        over_cnt_nx = '0;
                    end
                end
                A_TRIP: begin
                    if (rx < clr_lvl) begin
                        st_nx       = A_CLEAR;
                        over_cnt_nx = '0;
                    end
                end
                default: st_nx = A_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= A_CLEAR;
            over_cnt <= '0;
        end else begin
            st       <= st_nx;
            over_cnt <= over_cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
        end else begin
            alarm <= (st_nx == A_TRIP);
        end
    end

    // R8: a rising alarm follows an update strictly above the set level
    p_alarm_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> ($past(upd) && ($past(rx) > $past(set_lvl))));

    // R10: a falling alarm follows an update strictly below the clear level
    p_alarm_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm) |-> ($past(upd) && ($past(rx) < $past(clr_lvl))));

    // R9: without an update the alarm does not move
    p_alarm_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(alarm));
endmodule

// File: rtl/lossres_monitor.sv
module lossres_monitor
    import lossres_pkg::*;
#(
    parameter int DUTY_W     = 10,
    parameter int V_W        = 12,
    parameter int I_W        = 12,
    parameter int RX_W       = 16,
    parameter int RES_FRAC   = 8,
    parameter int DUTY_MIN   = 16,
    parameter int CUR_MIN    = 8,
    parameter int TRIP_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_strobe,
    input  logic [DUTY_W-1:0] duty_code,
    input  logic [V_W-1:0]    vin_code,
    input  logic [V_W-1:0]    vout_code,
    input  logic [I_W-1:0]    iload_code,
    input  logic [V_W-1:0]    diode_cal,
    input  logic [RX_W-1:0]   rfix_cal,
    input  logic [RX_W-1:0]   trip_level,
    input  logic [RX_W-1:0]   clear_level,
    output logic [RX_W-1:0]   rx_est,
    output logic              rx_valid,
    output logic              rx_alarm
);
    localparam int NUM_W = DUTY_W + V_W + RES_FRAC;
    localparam int DEN_W = DUTY_W + I_W;

    seq_state_t state, state_nx;

    logic [DUTY_W-1:0] cap_duty;
    logic [V_W-1:0]    cap_vin;
    logic [V_W-1:0]    cap_vout;
    logic [V_W-1:0]    cap_vd;
    logic [I_W-1:0]    cap_i;
    logic [RX_W-1:0]   cap_rfix;

    logic [NUM_W-1:0]  numer;
    logic [DEN_W-1:0]  denom;
    logic              skip;
    logic              div_start;
    logic [NUM_W-1:0]  div_quot;
    logic              div_done;
    logic [RX_W-1:0]   rx_sat;

    lossres_operand #(
        .DUTY_W(DUTY_W), .V_W(V_W), .I_W(I_W), .RX_W(RX_W),
        .RES_FRAC(RES_FRAC), .DUTY_MIN(DUTY_MIN), .CUR_MIN(CUR_MIN)
    ) u_operand (
        .duty(cap_duty), .vin(cap_vin), .vout(cap_vout), .vdrop(cap_vd),
        .iload(cap_i), .rfix(cap_rfix),
        .numer(numer), .denom(denom), .skip(skip)
    );

    assign div_start = (state == S_PREP) && !skip;

    lossres_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .num_in(numer), .den_in(denom),
        .quot(div_quot), .done(div_done)
    );

    generate
        if (NUM_W > RX_W) begin : g_sat
            always_comb begin
                if (|div_quot[NUM_W-1:RX_W]) begin
                    rx_sat = '1;
                end else begin
                    rx_sat = div_quot[RX_W-1:0];
                end
            end
        end else begin : g_nosat
            always_comb rx_sat = RX_W'(div_quot);
        end
    endgenerate

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (smp_strobe) state_nx = S_PREP;
            S_PREP: state_nx = skip ? S_IDLE : S_DIV;
            S_DIV:  if (div_done) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_duty <= '0;
            cap_vin  <= '0;
            cap_vout <= '0;
            cap_vd   <= '0;
            cap_i    <= '0;
            cap_rfix <= '0;
            rx_est   <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (state == S_IDLE && smp_strobe) begin
                cap_duty <= duty_code;
                cap_vin  <= vin_code;
                cap_vout <= vout_code;
                cap_vd   <= diode_cal;
                cap_i    <= iload_code;
                cap_rfix <= rfix_cal;
            end
            if (state == S_DIV && div_done) begin
                rx_est   <= rx_sat;
                rx_valid <= 1'b1;
            end
        end
    end

    lossres_alarm #(.RX_W(RX_W), .TRIP_COUNT(TRIP_COUNT)) u_alarm (
        .clk(clk), .rst(rst), .upd(rx_valid), .rx(rx_est),
        .set_lvl(trip_level), .clr_lvl(clear_level), .alarm(rx_alarm)
    );

    // R7: the estimate moves only together with the valid pulse
    p_est_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_est));

    // R7: valid is a single-cycle pulse
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R5: a skipped cycle returns to idle without publishing
    p_skip_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_PREP && skip) |=> (state == S_IDLE && !rx_valid));

    // R6: a strobe during a cycle leaves the captured operands alone
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && smp_strobe) |=> ($stable(cap_duty) && $stable(cap_i)
                                             && $stable(cap_vout)));
endmodule

// File: tb/tb_lossres_monitor.sv
`timescale 1ns/1ps
module tb_lossres_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_strobe = 1'b0;
    logic [9:0]  duty_code = '0;
    logic [11:0] vin_code = '0, vout_code = '0, iload_code = '0, diode_cal = '0;
    logic [15:0] rfix_cal = '0, trip_level = '0, clear_level = '0;
    logic [15:0] rx_est;
    logic        rx_valid, rx_alarm;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    lossres_monitor dut (
        .clk(clk), .rst(rst), .smp_strobe(smp_strobe), .duty_code(duty_code),
        .vin_code(vin_code), .vout_code(vout_code), .iload_code(iload_code),
        .diode_cal(diode_cal), .rfix_cal(rfix_cal), .trip_level(trip_level),
        .clear_level(clear_level), .rx_est(rx_est), .rx_valid(rx_valid),
        .rx_alarm(rx_alarm)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_rx(longint d, longint vg, longint v, longint vd,
                                        longint i, longint ry);
        longint num, q;
        num = d * vg * 256 - (v + vd) * 262144 - ry * i * 1024;
        if (num <= 0) return 0;
        q = num / (d * i);
        if (q > 65535) q = 65535;
        return q;
    endfunction

    // one sample cycle; returns whether a valid pulse came and after how many edges
    task automatic sample(input int d, input int vg, input int v, input int i,
                          output bit got, output int edges);
        int n;
        @(negedge clk);
        duty_code = 10'(d); vin_code = 12'(vg); vout_code = 12'(v); iload_code = 12'(i);
        smp_strobe = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk); smp_strobe = 1'b0;
        while (!rx_valid && n < 80) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        got = rx_valid;
        edges = n;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_est == 0, "R1 est", rx_est, 0);
        chk(rx_valid == 0, "R1 valid", rx_valid, 0);
        chk(rx_alarm == 0, "R1 alarm", rx_alarm, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_nominal();
        bit g; int e; longint x;
        diode_cal = 20; rfix_cal = 64;
        sample(512, 2000, 800, 400, g, e);
        x = model_rx(512, 2000, 800, 20, 400, 64);
        chk(g && rx_est == x, "R2 mid duty", rx_est, x);
        chk(e == 33, "R7 latency", e, 33);
        sample(700, 3000, 1500, 900, g, e);
        x = model_rx(700, 3000, 1500, 20, 900, 64);
        chk(g && rx_est == x, "R2 high duty", rx_est, x);
        diode_cal = 0; rfix_cal = 0;
        sample(300, 4000, 1000, 50, g, e);
        x = model_rx(300, 4000, 1000, 0, 50, 0);
        chk(g && rx_est == x, "R2 no calibration", rx_est, x);
        diode_cal = 20; rfix_cal = 64;
    endtask

    task automatic t_negative();
        bit g; int e;
        sample(512, 2000, 1500, 400, g, e);
        chk(g && rx_est == 0, "R3 negative numerator", rx_est, 0);
    endtask

    task automatic t_saturate();
        bit g; int e;
        diode_cal = 0; rfix_cal = 0;
        sample(16, 4095, 0, 8, g, e);
        chk(g && rx_est == 65535, "R4 saturation", rx_est, 65535);
        diode_cal = 20; rfix_cal = 64;
    endtask

    task automatic t_skip();
        bit g; int e; longint x;
        sample(512, 2000, 800, 400, g, e);
        x = model_rx(512, 2000, 800, 20, 400, 64);
        sample(15, 2000, 100, 400, g, e);
        chk(!g, "R5 duty below minimum no valid", g, 0);
        chk(rx_est == x, "R5 duty skip holds estimate", rx_est, x);
        sample(512, 2000, 100, 7, g, e);
        chk(!g, "R5 current below minimum no valid", g, 0);
        chk(rx_est == x, "R5 current skip holds estimate", rx_est, x);
    endtask

    task automatic t_busy();
        int n; int pulses; longint x;
        x = model_rx(512, 2000, 760, 20, 400, 64);
        @(negedge clk);
        duty_code = 512; vin_code = 2000; vout_code = 760; iload_code = 400;
        smp_strobe = 1'b1;
        @(negedge clk); smp_strobe = 1'b0;
        repeat (5) @(negedge clk);
        duty_code = 900; vout_code = 100; iload_code = 1000; smp_strobe = 1'b1;
        @(negedge clk); smp_strobe = 1'b0;
        pulses = 0;
        for (n = 0; n < 80; n++) begin
            @(negedge clk);
            if (rx_valid) begin
                pulses++;
                chk(rx_est == x, "R6 busy strobe ignored value", rx_est, x);
            end
        end
        chk(pulses == 1, "R6 single pulse", pulses, 1);
    endtask

    task automatic t_alarm_trip();
        bit g; int e;
        do_reset();
        sample(512, 2000, 700, 400, g, e);
        sample(512, 2000, 700, 400, g, e);
        chk(rx_alarm == 0, "R8 two high not tripped", rx_alarm, 0);
        sample(512, 2000, 700, 400, g, e);
        chk(rx_alarm == 1, "R8 third high trips", rx_alarm, 1);
        sample(512, 2000, 760, 400, g, e);
        chk(rx_alarm == 1, "R10 mid band holds", rx_alarm, 1);
        sample(512, 2000, 800, 400, g, e);
        chk(rx_alarm == 0, "R10 below clear drops", rx_alarm, 0);
    endtask

    task automatic t_alarm_restart();
        bit g; int e;
        do_reset();
        sample(512, 2000, 700, 400, g, e);
        sample(512, 2000, 700, 400, g, e);
        sample(512, 2000, 800, 400, g, e);
        sample(512, 2000, 700, 400, g, e);
        sample(512, 2000, 700, 400, g, e);
        chk(rx_alarm == 0, "R9 count restarted", rx_alarm, 0);
        sample(512, 2000, 700, 400, g, e);
        chk(rx_alarm == 1, "R9 trips after fresh run", rx_alarm, 1);
    endtask

    task automatic t_alarm_skip();
        bit g; int e;
        do_reset();
        sample(512, 2000, 700, 400, g, e);
        sample(512, 2000, 700, 400, g, e);
        sample(10, 2000, 700, 400, g, e);
        chk(rx_alarm == 0, "R5 skip leaves alarm low", rx_alarm, 0);
        sample(512, 2000, 700, 400, g, e);
        chk(rx_alarm == 1, "R5 skip keeps count", rx_alarm, 1);
    endtask

    initial begin
        diode_cal = 20; rfix_cal = 64; trip_level = 200; clear_level = 150;
        t_reset();
        t_nominal();
        t_negative();
        t_saturate();
        t_skip();
        t_busy();
        t_alarm_trip();
        t_alarm_restart();
        t_alarm_skip();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule